// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block is the front end of a small word-addressed shared memory serving several requesters. Each requester may issue four operations: a plain read, a plain write, a linked read that also arms a per-requester address reservation, and a conditional write. A conditional write only takes effect if the issuing requester still holds a live reservation on the same word. It reports success as 1 and failure as 0 instead of returning data. Software built on top of it can form spin locks and atomic read-modify-write loops by retrying the conditional write until it reports 1.

A fixed-priority arbiter accepts at most one operation per cycle, with lower-numbered requesters winning. The accepted operation reads or updates the storage and the reservation table in that same cycle. Its response appears, for exactly one cycle, on the following cycle.

Top module: `llsc_monitor`

## Requirements
- R1: While `rst_n` is low on a clock edge, every reservation is cleared, every storage word becomes zero and `rsp_valid` goes to zero. After reset, a read of any word returns 0 and a conditional write reports 0.
- R2: `req_ready` has at most one bit set. That bit belongs to the lowest-numbered requester whose `req_valid` is high, and it is set whenever any `req_valid` is high outside reset.
- R3: An accepted operation (valid and ready both high at a clock edge) raises only that requester's `rsp_valid` bit, for exactly the next cycle.
- R4: Operation codes are 2'b00 read, 2'b01 write, 2'b10 linked read and 2'b11 conditional write. A read and a linked read return the addressed word. A write stores `req_wdata` and responds with 0.
- R5: A conditional write by a requester whose reservation is live and on the same address stores its data and responds with 1. Its response data is always 0 or 1.
- R6: A write or a successful conditional write by another requester to the reserved word cancels the reservation, even when the written value is zero. A later conditional write then responds with 0 and leaves the word unchanged.
- R7: A conditional write with no live reservation, or to an address other than the reserved one, responds with 0 and leaves storage unchanged.
- R8: A conditional write always cancels the issuing requester's own reservation, whether it succeeds or fails.
- R9: A new linked read replaces the requester's previous reservation.
- R10: When two requesters present conditional writes to the same reserved word in the same cycle, the lower-numbered one succeeds and the other responds with 0.
- R11: A requester's own plain write, and writes by others to different addresses, do not cancel its reservation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | N_REQ | Per-requester operation request |
| req_ready | output | N_REQ | Per-requester acceptance, one-hot or zero |
| req_op | input | N_REQ x 2 | Operation code per requester |
| req_addr | input | N_REQ x ADDR_W | Word address per requester |
| req_wdata | input | N_REQ x DATA_W | Write data per requester |
| rsp_valid | output | N_REQ | One-cycle response strobe for the requester served in the previous cycle |
| rsp_data | output | DATA_W | Read data, write acknowledge 0, or conditional-write status |

## Verification
The bench builds the block with three requesters, an 8-word store and 32-bit data. With three requesters, a priority chain of three contenders can be exercised. A third party can break a reservation while the two others contend. The small store makes address aliasing between reservations and writes frequent, and every word can be inspected directly. A behavioural model of storage and reservations is checked against the ports on every clock, alongside directed lock sequences with literal expected results.

// File: rtl/llsc_pkg.sv
// Shared operation encoding for the reservation monitor.
package llsc_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_LINK  = 2'b10,
        OP_COND  = 2'b11
    } llsc_op_e;
endpackage

// File: rtl/llsc_prio_arb.sv
// Fixed-priority arbiter: grants the lowest-numbered active request.
// Assumes requests are level signals held until granted.
module llsc_prio_arb #(
    parameter int N_REQ = 2,
    localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic [N_REQ-1:0] req,
    output logic [N_REQ-1:0] gnt,
    output logic [IDX_W-1:0] gnt_idx,
    output logic             any
);
    // Scan from the top so the lowest index is the last to overwrite.
    always_comb begin
        gnt_idx = '0;
        any     = 1'b0;
        for (int i = N_REQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt_idx = IDX_W'(i);
                any     = 1'b1;
            end
        end
        gnt = '0;
        if (any) gnt[gnt_idx] = 1'b1;
    end
endmodule

// File: rtl/llsc_resv_table.sv
// Per-requester reservation registers (valid bit plus word address).
// Assumes at most one operation is applied per cycle (op_fire).
// A linked read arms the owner's entry; a conditional write disarms it;
// a committed write by any requester disarms other entries on that word.
module llsc_resv_table
    import llsc_pkg::*;
#(
    parameter int N_REQ  = 2,
    parameter int ADDR_W = 4,
    localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_fire,
    input  logic [IDX_W-1:0]  op_idx,
    input  llsc_op_e          op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              write_commit,
    output logic              cond_ok
);
    logic [N_REQ-1:0]             rv;
    logic [N_REQ-1:0][ADDR_W-1:0] ra;

    for (genvar g = 0; g < N_REQ; g++) begin : g_entry
        // Update one requester's reservation entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rv[g] <= 1'b0;
                ra[g] <= '0;
            end else if (op_fire) begin
                if (op_idx == IDX_W'(g)) begin
                    if (op_kind == OP_LINK) begin
                        rv[g] <= 1'b1;
                        ra[g] <= op_addr;
                    end else if (op_kind == OP_COND) begin
                        rv[g] <= 1'b0;
                    end
                end else if (write_commit && rv[g] && (ra[g] == op_addr)) begin
                    rv[g] <= 1'b0;
                end
            end
        end
    end

    // Conditional write may commit only on a live, matching reservation.
    always_comb cond_ok = rv[op_idx] && (ra[op_idx] == op_addr);
endmodule

// File: rtl/llsc_word_store.sv
// Register-based word storage with combinational read and one write port.
// Assumes the read and write address are the same accepted operation's.
module llsc_word_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Clear all words on reset, otherwise apply the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Read the addressed word before any write of this cycle.
    always_comb rdata = mem[addr];
endmodule

// File: rtl/llsc_monitor.sv
// Top: arbitrates requesters, performs one operation per cycle against
// the word store and reservation table, returns a registered response.
// Assumes requesters hold valid and operands stable until ready.
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int N_REQ  = 2,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_REQ-1:0]              req_valid,
    output logic [N_REQ-1:0]              req_ready,
    input  logic [N_REQ-1:0][1:0]         req_op,
    input  logic [N_REQ-1:0][ADDR_W-1:0]  req_addr,
    input  logic [N_REQ-1:0][DATA_W-1:0]  req_wdata,
    output logic [N_REQ-1:0]              rsp_valid,
    output logic [DATA_W-1:0]             rsp_data
);
    localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

    logic [N_REQ-1:0]  gnt;
    logic [IDX_W-1:0]  gnt_idx;
    logic              any_req;
    logic              fire;
    llsc_op_e          sel_op;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_wdata;
    logic              cond_ok;
    logic              write_commit;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rsp_next;

    llsc_prio_arb #(.N_REQ(N_REQ)) u_arb (
        .req     (req_valid),
        .gnt     (gnt),
        .gnt_idx (gnt_idx),
        .any     (any_req)
    );

    // Steer the granted requester's operands and gate acceptance in reset.
    always_comb begin
        fire      = any_req && rst_n;
        req_ready = rst_n ? gnt : '0;
        sel_op    = llsc_op_e'(req_op[gnt_idx]);
        sel_addr  = req_addr[gnt_idx];
        sel_wdata = req_wdata[gnt_idx];
    end

    // A write lands for plain writes and for conditional writes that hold.
    always_comb write_commit = fire &&
        ((sel_op == OP_STORE) || ((sel_op == OP_COND) && cond_ok));

    llsc_resv_table #(.N_REQ(N_REQ), .ADDR_W(ADDR_W)) u_resv (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_fire      (fire),
        .op_idx       (gnt_idx),
        .op_kind      (sel_op),
        .op_addr      (sel_addr),
        .write_commit (write_commit),
        .cond_ok      (cond_ok)
    );

    llsc_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (write_commit),
        .addr  (sel_addr),
        .wdata (sel_wdata),
        .rdata (rd_word)
    );

    // Choose the response payload for the accepted operation.
    always_comb begin
        case (sel_op)
            OP_LOAD, OP_LINK: rsp_next = rd_word;
            OP_COND:          rsp_next = {{(DATA_W-1){1'b0}}, cond_ok};
            default:          rsp_next = '0;
        endcase
    end

    // Register the one-cycle response toward the served requester.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= fire ? gnt : '0;
            if (fire) rsp_data <= rsp_next;
        end
    end
endmodule

// File: rtl/llsc_monitor_chk.sv
// Port-level checker for llsc_monitor, attached with bind below.
module llsc_monitor_chk
    import llsc_pkg::*;
#(
    parameter int N_REQ  = 2,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [N_REQ-1:0]             req_valid,
    input logic [N_REQ-1:0]             req_ready,
    input logic [N_REQ-1:0][1:0]        req_op,
    input logic [N_REQ-1:0][ADDR_W-1:0] req_addr,
    input logic [N_REQ-1:0]             rsp_valid,
    input logic [DATA_W-1:0]            rsp_data
);
    logic [N_REQ-1:0] hs;
    logic             hs_cond;
    logic             hs_store;
    logic             cond_q;
    logic             store_q;
    logic [ADDR_W-1:0] unused_addr;

    // Decode which operation kind was accepted this cycle.
    always_comb begin
        hs       = req_valid & req_ready;
        hs_cond  = 1'b0;
        hs_store = 1'b0;
        unused_addr = '0;
        for (int i = 0; i < N_REQ; i++) begin
            if (hs[i]) begin
                hs_cond  = (req_op[i] == OP_COND);
                hs_store = (req_op[i] == OP_STORE);
            end
            unused_addr = unused_addr ^ req_addr[i];
        end
    end

    // Remember the accepted kind for the response cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q  <= 1'b0;
            store_q <= 1'b0;
        end else begin
            cond_q  <= hs_cond;
            store_q <= hs_store;
        end
    end

    p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));
    p_req0_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid[0] |-> req_ready[0]);
    p_no_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_valid) |-> (|req_ready));
    p_ready_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0);
    p_rsp_after_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|hs) |=> (rsp_valid == $past(hs)));
    p_rsp_has_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid != '0) |-> (rsp_valid == $past(hs)));
    p_cond_binary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((rsp_valid != '0) && cond_q) |-> (rsp_data[DATA_W-1:1] == '0));
    p_store_ack_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((rsp_valid != '0) && store_q) |-> (rsp_data == '0));
    p_addr_known_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|hs) |-> !$isunknown(unused_addr));
endmodule

bind llsc_monitor llsc_monitor_chk #(
    .N_REQ(N_REQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
);

// File: tb/llsc_monitor_bench.sv
`timescale 1ns/1ps
module llsc_monitor_bench;
    import llsc_pkg::*;
    localparam int NR = 3;
    localparam int AW = 3;
    localparam int DW = 32;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NR-1:0]           req_valid = '0;
    logic [NR-1:0]           req_ready;
    logic [NR-1:0][1:0]      req_op = '0;
    logic [NR-1:0][AW-1:0]   req_addr = '0;
    logic [NR-1:0][DW-1:0]   req_wdata = '0;
    logic [NR-1:0]           rsp_valid;
    logic [DW-1:0]           rsp_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    llsc_monitor #(.N_REQ(NR), .ADDR_W(AW), .DATA_W(DW)) u_llsc_monitor (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, compared on every clock.
    int        m_mem [8];
    bit        m_rv  [NR];
    int        m_ra  [NR];
    logic [NR-1:0] e_ready, e_valid;
    logic [31:0]   e_data;
    int            g;
    bit            ok;

    always @(posedge clk) begin
        e_ready = '0; e_valid = '0; e_data = '0; g = -1;
        if (!rst_n) begin
            foreach (m_mem[k]) m_mem[k] = 0;
            foreach (m_rv[k]) m_rv[k] = 0;
        end else begin
            for (int i = 0; i < NR; i++) if (req_valid[i] && g < 0) g = i;
            if (g >= 0) begin
                int a;
                a = int'(req_addr[g]);
                e_ready[g] = 1'b1;
                e_valid[g] = 1'b1;
                case (req_op[g])
                    2'b00: e_data = m_mem[a];
                    2'b10: begin e_data = m_mem[a]; m_rv[g] = 1; m_ra[g] = a; end
                    default: begin
                        ok = (req_op[g] == 2'b01) || (m_rv[g] && m_ra[g] == a);
                        if (req_op[g] == 2'b11) begin
                            m_rv[g] = 0;
                            e_data = {31'd0, ok};
                        end
                        if (ok) begin
                            m_mem[a] = req_wdata[g];
                            for (int j = 0; j < NR; j++)
                                if (j != g && m_rv[j] && m_ra[j] == a) m_rv[j] = 0;
                        end
                    end
                endcase
            end
            chk("R2 model ready", 32'(req_ready), 32'(e_ready));
        end
        #2;
        chk("R3 model rsp_valid", 32'(rsp_valid), 32'(e_valid));
        if (e_valid != '0) chk("R4 model rsp_data", rsp_data, e_data);
    end

    task automatic do_op(int r, logic [1:0] o, int a, logic [31:0] d,
                         output logic [31:0] rd);
        @(negedge clk);
        req_valid[r] = 1'b1; req_op[r] = o;
        req_addr[r] = AW'(a); req_wdata[r] = d;
        do @(posedge clk); while (!req_ready[r]);
        @(negedge clk);
        req_valid[r] = 1'b0;
        rd = rsp_data;
        chk("R3 response strobe", 32'(rsp_valid), 32'(1 << r));
    endtask

    task automatic expect_op(string tag, int r, logic [1:0] o, int a,
                             logic [31:0] d, logic [31:0] e);
        logic [31:0] rd;
        do_op(r, o, a, d, rd);
        chk(tag, rd, e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 0);
        expect_op("R1 word zero", 0, OP_LOAD, 5, 0, 0);
        expect_op("R1 R7 cond without link", 1, OP_COND, 2, 32'h7, 0);
        expect_op("R7 storage unchanged", 0, OP_LOAD, 2, 0, 0);
        // R4: plain write and reads
        expect_op("R4 write ack", 0, OP_STORE, 3, 32'hA5, 0);
        expect_op("R4 read back", 1, OP_LOAD, 3, 0, 32'hA5);
        // R5: successful conditional write
        expect_op("R5 link read", 1, OP_LINK, 3, 0, 32'hA5);
        expect_op("R5 cond success", 1, OP_COND, 3, 32'h11, 1);
        expect_op("R5 stored", 2, OP_LOAD, 3, 0, 32'h11);
        // R8: reservation consumed
        expect_op("R8 second cond fails", 1, OP_COND, 3, 32'h22, 0);
        expect_op("R8 word kept", 2, OP_LOAD, 3, 0, 32'h11);
        // R6: zero write by another breaks it
        expect_op("R6 link", 0, OP_LINK, 4, 0, 0);
        expect_op("R6 zero write", 2, OP_STORE, 4, 0, 0);
        expect_op("R6 cond fails", 0, OP_COND, 4, 32'h1, 0);
        expect_op("R6 word still zero", 1, OP_LOAD, 4, 0, 0);
        expect_op("R6 link again", 0, OP_LINK, 4, 0, 0);
        expect_op("R6 write", 1, OP_STORE, 4, 32'h5, 0);
        expect_op("R6 cond fails 2", 0, OP_COND, 4, 32'h9, 0);
        expect_op("R6 word kept", 2, OP_LOAD, 4, 0, 32'h5);
        // R7: address mismatch
        expect_op("R7 link", 0, OP_LINK, 6, 0, 0);
        expect_op("R7 cond other addr", 0, OP_COND, 7, 32'h3, 0);
        expect_op("R7 word unchanged", 1, OP_LOAD, 7, 0, 0);
        // R9: new link replaces the old one
        expect_op("R9 link 1", 2, OP_LINK, 1, 0, 0);
        expect_op("R9 link 2", 2, OP_LINK, 2, 0, 0);
        expect_op("R9 cond old addr", 2, OP_COND, 1, 32'h31, 0);
        expect_op("R9 link 2 again", 2, OP_LINK, 2, 0, 0);
        expect_op("R9 cond new addr", 2, OP_COND, 2, 32'h33, 1);
        // R11: own write and unrelated writes keep the reservation
        expect_op("R11 link", 1, OP_LINK, 0, 0, 0);
        expect_op("R11 own write", 1, OP_STORE, 0, 32'h44, 0);
        expect_op("R11 other addr write", 0, OP_STORE, 5, 32'h66, 0);
        expect_op("R11 cond holds", 1, OP_COND, 0, 32'h55, 1);
        expect_op("R11 stored", 2, OP_LOAD, 0, 0, 32'h55);
        // R10: two conditional writes in the same cycle
        expect_op("R10 link r0", 0, OP_LINK, 6, 0, 0);
        expect_op("R10 link r1", 1, OP_LINK, 6, 0, 0);
        @(negedge clk);
        req_valid = 3'b011;
        req_op[0] = OP_COND; req_addr[0] = 3'd6; req_wdata[0] = 32'h70;
        req_op[1] = OP_COND; req_addr[1] = 3'd6; req_wdata[1] = 32'h71;
        @(posedge clk);
        chk("R10 R2 lower granted", 32'(req_ready), 32'h1);
        @(negedge clk);
        req_valid[0] = 1'b0;
        chk("R10 r0 strobe", 32'(rsp_valid), 32'h1);
        chk("R10 r0 succeeds", rsp_data, 1);
        @(posedge clk);
        chk("R10 R2 next granted", 32'(req_ready), 32'h2);
        @(negedge clk);
        req_valid[1] = 1'b0;
        chk("R10 r1 strobe", 32'(rsp_valid), 32'h2);
        chk("R10 r1 fails", rsp_data, 0);
        expect_op("R10 winner data", 2, OP_LOAD, 6, 0, 32'h70);
        // R2: three-way contention
        @(negedge clk);
        req_op = '0; req_addr[0] = 3'd3; req_addr[1] = 3'd0; req_addr[2] = 3'd2;
        req_valid = 3'b111;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            chk("R2 priority order", 32'(req_ready), 32'(1 << k));
            @(negedge clk);
            req_valid[k] = 1'b0;
        end
        @(negedge clk);
        chk("R3 strobe single cycle", 32'(rsp_valid), 0);
        // R1: reset clears storage and reservations
        expect_op("R1 link before reset", 0, OP_LINK, 3, 0, 32'h11);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        expect_op("R1 cond after reset", 0, OP_COND, 3, 32'h8, 0);
        expect_op("R1 storage cleared", 1, OP_LOAD, 3, 0, 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule